// File: doc/BRIEF.md
# DMA Controller Global Register Bank

This block holds the global control and status registers shared by all channels of a multi-channel DMA engine. A host writes or reads one 32-bit register per cycle through a single-cycle write strobe, a single-cycle read strobe and an 8-bit byte offset. Read data comes back registered one cycle later, together with a one-cycle valid pulse. The channels, which lie outside this block, raise interrupt-status bits through a per-bit set input.

Six registers sit on a 16-byte stride. Five of them are plain 32-bit latches. The status register is split in two halves. Its low half holds interrupt-status flags, which software clears by writing a 1 to each bit it wants cleared. Its high half holds interrupt-mask bits, which every write to the status register replaces outright.

Each accepted access also produces one trace record on the following cycle. The record carries the access kind, the offset, the data, the prior register contents, and a flag for unmapped offsets. An external event logger can collect these records without any extra decoding.

Top module: `dmac_gbank`

## Requirements
- R1: After reset `rvalid` and `ev_valid` are 0, `rdata` is 0, and every one of the six registers reads back as 0.
- R2: The registers at byte offsets 0x00 (control), 0x20 (priority), 0x30 (word count), 0x40 (ring size) and 0x50 (ring offset) return exactly the last 32-bit value written to them.
- R3: A write to the status register at 0x10 clears each bit of [15:0] whose write-data bit is 1 and leaves the other bits of [15:0] unchanged. For example, 0x00AB written with 0x00A0 becomes 0x000B.
- R4: Every write to 0x10 loads status bits [31:16] from write-data bits [31:16], even when those bits are zero. A status write whose low half is zero changes no flag: 0x000000FF written with 0xDEAD0000 becomes 0xDEAD00FF.
- R5: Each bit set in `stat_set[15:0]` ORs into status bit [n] at the next edge. When a set and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R6: An offset is unmapped when it is not a multiple of 0x10 or is 0x60 or above. A read of an unmapped offset returns 0. A write to an unmapped offset changes no register.
- R7: A write to one register leaves every other register unchanged, including after writes to unmapped offsets.
- R8: `rvalid` is high in exactly the cycle after `rd_en` was sampled high. That cycle's `rdata` is the addressed value, and `rdata` holds until the next read.
- R9: When `wr_en` and `rd_en` are both high, the write takes effect and the read returns the register's value from before that write.
- R10: One cycle after any access, `ev_valid` pulses for one cycle, with these fields:
  - `ev_subsys` is 5.
  - `ev_code` is 1 for a write, 2 for a read and 3 for both.
  - `ev_arg0` is the zero-extended offset.
  - `ev_arg1` is the write data for a write, otherwise the data returned by the read.
  - `ev_arg2` is the prior contents of the addressed register (0 if unmapped).
  - `ev_arg3` is 0.
  - `ev_flags` bit 0 marks an unmapped offset, bit 1 a write and bit 2 a read. All other flag bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| offset | input | 8 | Byte offset of the accessed register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid pulse |
| stat_set | input | 16 | Per-bit interrupt-status set from the channels |
| ev_valid | output | 1 | Trace record valid |
| ev_subsys | output | 4 | Trace subsystem code |
| ev_code | output | 4 | Trace access kind |
| ev_arg0 | output | 64 | Trace argument: offset |
| ev_arg1 | output | 64 | Trace argument: data |
| ev_arg2 | output | 64 | Trace argument: prior contents |
| ev_arg3 | output | 64 | Trace argument: reserved zero |
| ev_flags | output | 32 | Trace flags |

## Verification
The properties observe only the port boundary. They assume the strobes and the offset are known (never X) whenever reset is inactive, and they place no limit on how accesses or status sets are spaced. The stimulus keeps to this assumption: it drives every input to a defined value on the falling edge, and it mixes directed sequences with a randomised run. That run includes back-to-back accesses, simultaneous read and write, unmapped and misaligned offsets, and status sets that collide with clears.

// File: rtl/dmac_gbank_pkg.sv
package dmac_gbank_pkg;

   typedef enum logic [3:0] {
      EVT_NONE       = 4'd0,
      EVT_WRITE      = 4'd1,
      EVT_READ       = 4'd2,
      EVT_WRITE_READ = 4'd3
   } evt_code_e;

   localparam int unsigned FLG_UNMAPPED = 0;
   localparam int unsigned FLG_WRITE    = 1;
   localparam int unsigned FLG_READ     = 2;
   localparam int unsigned FLG_USED     = 3;

   function automatic evt_code_e evt_kind(input logic wr, input logic rd);
      evt_code_e k;
      unique case ({wr, rd})
         2'b10:   k = EVT_WRITE;
         2'b01:   k = EVT_READ;
         2'b11:   k = EVT_WRITE_READ;
         default: k = EVT_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/dmac_gbank_decode.sv
module dmac_gbank_decode #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned NUM_REGS    = 6,
   parameter int unsigned STRIDE_LOG2 = 4
) (
   input  logic [ADDR_W-1:0]   offset,
   output logic [NUM_REGS-1:0] sel,
   output logic                unmapped
);
   localparam int unsigned IDX_W = ADDR_W - STRIDE_LOG2;

   logic             aligned;
   logic [IDX_W-1:0] idx;

   assign aligned = (offset[STRIDE_LOG2-1:0] == '0);
   assign idx     = offset[ADDR_W-1:STRIDE_LOG2];

   always_comb begin
      for (int i = 0; i < int'(NUM_REGS); i++) begin
         sel[i] = aligned && (idx == IDX_W'(i));
      end
   end

   assign unmapped = ~|sel;

endmodule

// File: rtl/dmac_gbank_latch.sv
module dmac_gbank_latch #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= d;
      end
   end
endmodule

// File: rtl/dmac_gbank_status.sv
module dmac_gbank_status #(
   parameter int unsigned W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [W-1:0]   d,
   input  logic [W/2-1:0] set,
   output logic [W-1:0]   q
);
   localparam int unsigned HALF = W / 2;

   logic [HALF-1:0] clr_mask;
   logic [HALF-1:0] flags_nxt;

   // Clearing is applied first and setting afterwards, so a bit that
   // receives both in the same cycle ends up set.
   assign clr_mask  = we ? d[HALF-1:0] : '0;
   assign flags_nxt = (q[HALF-1:0] & ~clr_mask) | set;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q[HALF-1:0] <= flags_nxt;
         if (we) begin
            q[W-1:HALF] <= d[W-1:HALF];
         end
      end
   end
endmodule

// File: rtl/dmac_gbank_trace.sv
module dmac_gbank_trace
   import dmac_gbank_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ARG_W     = 64,
   parameter int unsigned FLAG_W    = 32,
   parameter int unsigned SUBSYS_W  = 4,
   parameter int unsigned SUBSYS_ID = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                rd,
   input  logic                unmapped,
   input  logic [ADDR_W-1:0]   offset,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [DATA_W-1:0]   prior,
   output logic                ev_valid,
   output logic [SUBSYS_W-1:0] ev_subsys,
   output logic [3:0]          ev_code,
   output logic [ARG_W-1:0]    ev_arg0,
   output logic [ARG_W-1:0]    ev_arg1,
   output logic [ARG_W-1:0]    ev_arg2,
   output logic [ARG_W-1:0]    ev_arg3,
   output logic [FLAG_W-1:0]   ev_flags
);
   logic              access;
   logic [DATA_W-1:0] data_arg;
   logic [FLAG_W-1:0] flags_nxt;

   assign access   = wr | rd;
   assign data_arg = wr ? wdata : prior;

   always_comb begin
      flags_nxt               = '0;
      flags_nxt[FLG_UNMAPPED] = unmapped;
      flags_nxt[FLG_WRITE]    = wr;
      flags_nxt[FLG_READ]     = rd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_valid <= 1'b0;
         ev_code  <= EVT_NONE;
         ev_arg0  <= '0;
         ev_arg1  <= '0;
         ev_arg2  <= '0;
         ev_flags <= '0;
      end else begin
         ev_valid <= access;
         if (access) begin
            ev_code  <= evt_kind(wr, rd);
            ev_arg0  <= ARG_W'(offset);
            ev_arg1  <= ARG_W'(data_arg);
            ev_arg2  <= ARG_W'(prior);
            ev_flags <= flags_nxt;
         end
      end
   end

   assign ev_subsys = SUBSYS_W'(SUBSYS_ID);
   assign ev_arg3   = '0;

endmodule

// File: rtl/dmac_gbank.sv
module dmac_gbank
   import dmac_gbank_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ARG_W       = 64,
   parameter int unsigned FLAG_W      = 32,
   parameter int unsigned NUM_REGS    = 6,
   parameter int unsigned STRIDE_LOG2 = 4,
   parameter int unsigned STAT_IDX    = 1,
   parameter int unsigned SUBSYS_W    = 4,
   parameter int unsigned SUBSYS_ID   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   offset,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                rvalid,
   input  logic [DATA_W/2-1:0] stat_set,
   output logic                ev_valid,
   output logic [SUBSYS_W-1:0] ev_subsys,
   output logic [3:0]          ev_code,
   output logic [ARG_W-1:0]    ev_arg0,
   output logic [ARG_W-1:0]    ev_arg1,
   output logic [ARG_W-1:0]    ev_arg2,
   output logic [ARG_W-1:0]    ev_arg3,
   output logic [FLAG_W-1:0]   ev_flags
);
   localparam int unsigned SLOTS = 1 << (ADDR_W - STRIDE_LOG2);

   if (DATA_W % 2 != 0) begin : g_bad_data_w
      $error("dmac_gbank: DATA_W must be even");
   end
   if (ARG_W < DATA_W || ARG_W < ADDR_W) begin : g_bad_arg_w
      $error("dmac_gbank: ARG_W must hold both data and offset");
   end
   if (FLAG_W < FLG_USED) begin : g_bad_flag_w
      $error("dmac_gbank: FLAG_W too narrow");
   end
   if (STRIDE_LOG2 >= ADDR_W || NUM_REGS > SLOTS) begin : g_bad_map
      $error("dmac_gbank: register map does not fit the offset");
   end
   if (STAT_IDX >= NUM_REGS) begin : g_bad_stat
      $error("dmac_gbank: STAT_IDX out of range");
   end
   if (SUBSYS_ID >= (1 << SUBSYS_W)) begin : g_bad_subsys
      $error("dmac_gbank: SUBSYS_ID does not fit");
   end

   logic [NUM_REGS-1:0] sel;
   logic                unmapped;
   logic [DATA_W-1:0]   reg_q [NUM_REGS];
   logic [DATA_W-1:0]   prior;

   dmac_gbank_decode #(
      .ADDR_W      (ADDR_W),
      .NUM_REGS    (NUM_REGS),
      .STRIDE_LOG2 (STRIDE_LOG2)
   ) u_dec (
      .offset   (offset),
      .sel      (sel),
      .unmapped (unmapped)
   );

   for (genvar i = 0; i < int'(NUM_REGS); i++) begin : g_reg
      if (i == int'(STAT_IDX)) begin : g_stat
         dmac_gbank_status #(.W(DATA_W)) u_stat (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en & sel[i]),
            .d     (wdata),
            .set   (stat_set),
            .q     (reg_q[i])
         );
      end else begin : g_plain
         dmac_gbank_latch #(.W(DATA_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en & sel[i]),
            .d     (wdata),
            .q     (reg_q[i])
         );
      end
   end

   // AND-OR mux over a one-hot select; unmapped gives zero.
   always_comb begin
      prior = '0;
      for (int i = 0; i < int'(NUM_REGS); i++) begin
         prior = prior | (sel[i] ? reg_q[i] : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd_en;
         if (rd_en) begin
            rdata <= prior;
         end
      end
   end

   dmac_gbank_trace #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .ARG_W     (ARG_W),
      .FLAG_W    (FLAG_W),
      .SUBSYS_W  (SUBSYS_W),
      .SUBSYS_ID (SUBSYS_ID)
   ) u_trc (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_en),
      .rd        (rd_en),
      .unmapped  (unmapped),
      .offset    (offset),
      .wdata     (wdata),
      .prior     (prior),
      .ev_valid  (ev_valid),
      .ev_subsys (ev_subsys),
      .ev_code   (ev_code),
      .ev_arg0   (ev_arg0),
      .ev_arg1   (ev_arg1),
      .ev_arg2   (ev_arg2),
      .ev_arg3   (ev_arg3),
      .ev_flags  (ev_flags)
   );

endmodule

// File: rtl/dmac_gbank_chk.sv
module dmac_gbank_chk #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ARG_W       = 64,
   parameter int unsigned FLAG_W      = 32,
   parameter int unsigned NUM_REGS    = 6,
   parameter int unsigned STRIDE_LOG2 = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] offset,
   input logic [DATA_W-1:0] rdata,
   input logic              rvalid,
   input logic              ev_valid,
   input logic [ARG_W-1:0]  ev_arg0,
   input logic [FLAG_W-1:0] ev_flags
);
   logic off_unmapped;
   assign off_unmapped = (offset[STRIDE_LOG2-1:0] != '0) ||
                         (32'(offset >> STRIDE_LOG2) >= NUM_REGS);

   AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rvalid);                                              // R8
   AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rvalid);                                            // R8
   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));                                     // R8
   AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && off_unmapped) |=> (rdata == '0));                     // R6
   AST_EVENT_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || rd_en) |=> ev_valid);                                 // R10
   AST_EVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en || rd_en) |=> !ev_valid);                               // R10
   AST_EVENT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || rd_en) |=> (ev_arg0 == ARG_W'($past(offset))));       // R10
   AST_EVENT_UNMAPPED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || rd_en) |=> (ev_flags[0] == $past(off_unmapped)));     // R6
endmodule

bind dmac_gbank dmac_gbank_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .ARG_W       (ARG_W),
   .FLAG_W      (FLAG_W),
   .NUM_REGS    (NUM_REGS),
   .STRIDE_LOG2 (STRIDE_LOG2)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .offset   (offset),
   .rdata    (rdata),
   .rvalid   (rvalid),
   .ev_valid (ev_valid),
   .ev_arg0  (ev_arg0),
   .ev_flags (ev_flags)
);

// File: tb/sim_dmac_gbank.sv
`timescale 1ns/1ps
module sim_dmac_gbank;
   localparam real HALF_NS = 2.0;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en, rd_en;
   logic [7:0]  offset;
   logic [31:0] wdata, rdata;
   logic        rvalid;
   logic [15:0] stat_set;
   logic        ev_valid;
   logic [3:0]  ev_subsys, ev_code;
   logic [63:0] ev_arg0, ev_arg1, ev_arg2, ev_arg3;
   logic [31:0] ev_flags;

   always #(HALF_NS) clk = ~clk;

   dmac_gbank u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .offset(offset), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
      .stat_set(stat_set), .ev_valid(ev_valid), .ev_subsys(ev_subsys),
      .ev_code(ev_code), .ev_arg0(ev_arg0), .ev_arg1(ev_arg1),
      .ev_arg2(ev_arg2), .ev_arg3(ev_arg3), .ev_flags(ev_flags)
   );

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   // behavioural reference state
   logic [31:0] m_reg [6];
   logic [31:0] m_rdata;

   task automatic cmp(string req, string what, logic [63:0] got, logic [63:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
      end
   endtask

   function automatic bit is_mapped(logic [7:0] o);
      return (o[3:0] == 4'h0) && (o < 8'h60);
   endfunction

   // One clock: drive on the falling edge, check just after the rising edge.
   task automatic step(bit w, bit r, logic [7:0] o, logic [31:0] d,
                       logic [15:0] s, string req);
      logic [31:0] prior;
      int          idx;
      @(negedge clk);
      wr_en = w; rd_en = r; offset = o; wdata = d; stat_set = s;
      @(posedge clk);
      #1;
      idx   = int'(o >> 4);
      prior = is_mapped(o) ? m_reg[idx] : 32'h0;
      if (r) m_rdata = prior;
      // model update
      if (w && is_mapped(o) && idx != 1) m_reg[idx] = d;
      if (w && is_mapped(o) && idx == 1) begin
         m_reg[1][15:0]  = m_reg[1][15:0] & ~d[15:0];
         m_reg[1][31:16] = d[31:16];
      end
      m_reg[1][15:0] = m_reg[1][15:0] | s;
      // compare
      cmp("R8", "rvalid", 64'(rvalid), 64'(r));
      cmp(req, "rdata", 64'(rdata), 64'(m_rdata));
      cmp("R10", "ev_valid", 64'(ev_valid), 64'(w | r));
      if (w | r) begin
         cmp("R10", "ev_subsys", 64'(ev_subsys), 64'd5);
         cmp("R10", "ev_code", 64'(ev_code), w ? (r ? 64'd3 : 64'd1) : 64'd2);
         cmp("R10", "ev_arg0", ev_arg0, 64'(o));
         cmp("R10", "ev_arg1", ev_arg1, w ? 64'(d) : 64'(prior));
         cmp("R10", "ev_arg2", ev_arg2, 64'(prior));
         cmp("R10", "ev_arg3", ev_arg3, 64'h0);
         cmp(is_mapped(o) ? "R10" : "R6", "ev_flags", 64'(ev_flags),
             64'({29'h0, r, w, !is_mapped(o)}));
      end
   endtask

   task automatic wr(logic [7:0] o, logic [31:0] d, string req);
      step(1'b1, 1'b0, o, d, 16'h0, req);
   endtask
   task automatic rd(logic [7:0] o, string req);
      step(1'b0, 1'b1, o, 32'h0, 16'h0, req);
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; offset = '0;
      wdata = '0; stat_set = '0;
      for (int i = 0; i < 6; i++) m_reg[i] = 32'h0;
      m_rdata = 32'h0;
      repeat (4) @(posedge clk);
      #1;
      cmp("R1", "rvalid in reset", 64'(rvalid), 64'h0);
      cmp("R1", "ev_valid in reset", 64'(ev_valid), 64'h0);
      cmp("R1", "rdata in reset", 64'(rdata), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents
      for (int i = 0; i < 6; i++) rd(8'(i << 4), "R1");

      // R2 / R7: plain latches and isolation
      wr(8'h00, 32'h1234_5678, "R2");
      rd(8'h00, "R2");
      wr(8'h20, 32'hCAFE_BABE, "R2");
      wr(8'h30, 32'h1357_9BDF, "R2");
      wr(8'h40, 32'h2468_ACE0, "R2");
      wr(8'h50, 32'hFEED_FACE, "R2");
      for (int i = 0; i < 6; i++) rd(8'(i << 4), "R7");

      // R5 / R4: channel set, then mask load
      step(1'b0, 1'b0, 8'h00, 32'h0, 16'h00AB, "R5");
      wr(8'h10, 32'hFFFF_0000, "R4");
      rd(8'h10, "R5");
      // R3: write-1-to-clear low half, mask replaced with zero
      wr(8'h10, 32'h0000_00A0, "R3");
      rd(8'h10, "R3");
      // R4: zero low half clears nothing, mask replaced
      step(1'b0, 1'b0, 8'h00, 32'h0, 16'h00F4, "R5");
      wr(8'h10, 32'hDEAD_0000, "R4");
      rd(8'h10, "R4");
      // R5: set and clear of the same bit in one cycle
      step(1'b1, 1'b0, 8'h10, 32'h0000_0003, 16'h0001, "R5");
      rd(8'h10, "R5");

      // R6: unmapped and misaligned offsets
      rd(8'h80, "R6");
      wr(8'h80, 32'hAAAA_5555, "R6");
      wr(8'h14, 32'h5555_AAAA, "R6");
      wr(8'h60, 32'h0F0F_0F0F, "R6");
      rd(8'h80, "R6");
      rd(8'h14, "R6");
      for (int i = 0; i < 6; i++) rd(8'(i << 4), "R7");

      // R9: simultaneous write and read
      step(1'b1, 1'b1, 8'h00, 32'hA5A5_0001, 16'h0, "R9");
      rd(8'h00, "R9");
      step(1'b1, 1'b1, 8'h10, 32'h1111_00FF, 16'h0, "R9");
      rd(8'h10, "R9");

      // R8: idle cycles, rdata held
      repeat (3) step(1'b0, 1'b0, 8'h00, 32'h0, 16'h0, "R8");

      // Mixed traffic
      for (int n = 0; n < 400; n++) begin
         logic [7:0]  o;
         logic [15:0] s;
         int          pick;
         pick = $urandom_range(0, 9);
         case (pick)
            6:       o = 8'h80;
            7:       o = 8'h14;
            8:       o = 8'hF0;
            9:       o = 8'h60;
            default: o = 8'(pick << 4);
         endcase
         s = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), o,
              $urandom, s, "R7");
      end

      step(1'b0, 1'b0, 8'h00, 32'h0, 16'h0, "R8");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule